// File: doc/BRIEF.md
# Cascadable Reset Release Stage

This stage turns a "clocks are good" indication into a delayed, clean release of a reset. Its start input, usually the clock generator's lock flag, is brought into the local clock domain by an optional flop synchronizer. Once the synchronized start and the enable are both high, a counter runs for a fixed number of clock cycles. The registered reset output is then released.

Stages are chained to build an ordered release sequence, for example delay lines first, then serializers, then their controller. Each stage's inverted reset output drives the next stage's start input, with the synchronizer bypassed on the downstream stages. When the enable is low, or the start input drops, the output asserts again and the full delay restarts. A run-time reset of any length clears every stage at once, and the whole chain then releases again in order.

Top module: `rstseq_stage`

## Requirements
- R1: While `rst_i` is high, `rst_o` is 1 and `rst_n_o` is 0 whatever the other inputs are. The assertion takes effect without waiting for a clock edge.
- R2: With `SYNC_STAGES`=2 and `enable_i` and `start_i` held high, `rst_o` falls on clock edge number `SYNC_STAGES`+`DELAY_CYCLES`. Edges are counted from the first edge that samples `start_i` high.
- R3: A low `enable_i` sampled on an edge makes `rst_o` 1 after that edge, whatever the progress of the delay.
- R4: After `start_i` goes low, `rst_o` is 1 no later than `SYNC_STAGES`+1 edges later.
- R5: Any interruption by a low enable, a low start or a reset restarts the full delay from zero.
- R6: `rst_n_o` is always the complement of `rst_o`.
- R7: A stage whose `start_i` is driven by the previous stage's `rst_n_o` releases exactly `DELAY_CYCLES` edges after the previous stage, when both use the same clock and `SYNC_STAGES`=0.
- R8: After a run-time reset held for more than 32 cycles, a chain of stages releases again in its original order with the original spacing.
- R9: Once released, `rst_o` stays 0 for as long as the synchronized start and `enable_i` stay high.
- R10: With `SYNC_STAGES`=0, `start_i` is used without synchronization, and `rst_o` falls on the `DELAY_CYCLES`-th edge that samples `start_i` and `enable_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stage clock |
| rst_i | input | 1 | Active-high reset, asserted asynchronously |
| enable_i | input | 1 | Low holds the output in reset (synchronous to `clk_i`) |
| start_i | input | 1 | Lock flag or previous stage's `rst_n_o` |
| rst_o | output | 1 | Registered active-high reset for downstream logic |
| rst_n_o | output | 1 | Registered complement, for the next stage's start |

## Verification
The clocked checks assume that `enable_i` is synchronous to `clk_i`. They also assume that `start_i` either goes through the synchronizer or already comes from a flop on the same clock. The stimulus therefore changes `enable_i` and `start_i` only at falling clock edges, and downstream stages take their start straight from the previous stage's registered `rst_n_o`. `rst_i` is the only input the checks allow to change independently of the clock. The bench changes it away from the rising edge and samples the outputs before the next rising edge, which confirms that assertion does not wait for a clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Registered outputs of one stage.
    typedef struct packed {
        logic rst;
        logic rst_n;
    } rel_state_t;

    localparam rel_state_t REL_HELD = '{rst: 1'b1, rst_n: 1'b0};

    // Counter width able to hold the value 'limit'.
    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Start already comes from a flop on this clock.
            logic unused_bypass;
            assign unused_bypass = clk_i ^ rst_i;
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_d, sh_q;

            always_comb begin
                sh_d    = sh_q << 1;
                sh_d[0] = async_i;
            end

            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) sh_q <= '0;
                else       sh_q <= sh_d;
            end

            assign sync_o = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rstseq_counter.sv
module rstseq_counter #(
    parameter int DELAY = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    output logic full_next_o
);

    localparam int CW = rstseq_pkg::cnt_bits(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear_i)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;          // saturate
        else                    cnt_d = cnt_q + 1'b1;
        full_next_o = (cnt_d == LAST);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

endmodule

// File: rtl/rstseq_stage.sv
module rstseq_stage #(
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic start_i,
    output logic rst_o,
    output logic rst_n_o
);

    import rstseq_pkg::*;

    logic       start_s;
    logic       hold;
    logic       full_next;
    rel_state_t st_d, st_q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (start_i),
        .sync_o  (start_s)
    );

    rstseq_counter #(.DELAY(DELAY_CYCLES)) u_cnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clear_i     (hold),
        .full_next_o (full_next)
    );

    always_comb begin
        hold        = !start_s || !enable_i;
        st_d.rst    = !full_next;
        st_d.rst_n  = full_next;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= REL_HELD;
        else       st_q <= st_d;
    end

    assign rst_o   = st_q.rst;
    assign rst_n_o = st_q.rst_n;

    // R3
    en_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> rst_o);

    // R4
    start_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_s |=> rst_o);

    // R9
    stay_released_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_o && start_s && enable_i) |=> !rst_o);

    // R2
    release_qual_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_o) |-> ($past(enable_i) && $past(start_s)));

endmodule

// File: tb/tb_rstseq_stage.sv
`timescale 1ns/1ps
module tb_rstseq_stage;

    localparam int DLY = 4;
    localparam int SYN = 2;

    logic clk = 1'b0;
    logic rst_i, en1, en2, start;
    logic r1, rn1, r2, rn2, r3, rn3;
    int   total = 0;
    int   bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    rstseq_stage #(.SYNC_STAGES(SYN), .DELAY_CYCLES(DLY)) dut (
        .clk_i(clk), .rst_i(rst_i), .enable_i(en1), .start_i(start),
        .rst_o(r1), .rst_n_o(rn1));
    rstseq_stage #(.SYNC_STAGES(0), .DELAY_CYCLES(DLY)) dut_s2 (
        .clk_i(clk), .rst_i(rst_i), .enable_i(en2), .start_i(rn1),
        .rst_o(r2), .rst_n_o(rn2));
    rstseq_stage #(.SYNC_STAGES(0), .DELAY_CYCLES(DLY)) dut_s3 (
        .clk_i(clk), .rst_i(rst_i), .enable_i(1'b1), .start_i(rn2),
        .rst_o(r3), .rst_n_o(rn3));

    // Per-edge table for the first stage: {enable, start, expected rst_o}
    localparam logic [2:0] VEC [0:22] = '{
        3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b110, 3'b110, 3'b011,
        3'b111, 3'b111, 3'b111, 3'b110, 3'b100, 3'b100, 3'b101, 3'b111,
        3'b101, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b110
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int f1, output int f2, output int f3);
        f1 = 0; f2 = 0; f3 = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (f1 == 0 && !r1) f1 = n;
            if (f2 == 0 && !r2) f2 = n;
            if (f3 == 0 && !r3) f3 = n;
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f1, f2, f3;
        rst_i = 1'b1; en1 = 1'b1; en2 = 1'b1; start = 1'b1;
        repeat (3) @(negedge clk);
        // R1: held in reset even with start and enable high
        chk(r1 && r2 && r3, "R1 reset state rst_o", {r1, r2, r3}, 7);
        chk(!rn1 && !rn2 && !rn3, "R1 reset state rst_n_o", {rn1, rn2, rn3}, 0);
        start = 1'b0;
        @(negedge clk);
        rst_i = 1'b0;

        // Table: R2 release, R3 enable, R4 start drop, R5 restart, R6 complement
        for (int i = 0; i < 23; i++) begin
            en1   = VEC[i][2];
            start = VEC[i][1];
            @(negedge clk);
            chk(r1 == VEC[i][0], "R2/R3/R4/R5 table rst_o", r1, VEC[i][0]);
            chk(rn1 == !r1, "R6 complement", rn1, !r1);
        end

        // Chain from reset: R2, R7, R10
        rst_i = 1'b1; start = 1'b0; en1 = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b1; rst_i = 1'b0;
        measure(f1, f2, f3);
        chk(f1 == SYN + DLY, "R2 first stage release edge", f1, SYN + DLY);
        chk(f2 == SYN + 2 * DLY, "R7 second stage release edge", f2, SYN + 2 * DLY);
        chk(f3 == SYN + 3 * DLY, "R10 third stage release edge", f3, SYN + 3 * DLY);

        // R9: stays released
        repeat (50) @(negedge clk);
        chk(!r1 && !r2 && !r3, "R9 stays released", {r1, r2, r3}, 0);

        // R3 on a middle stage, then restart (R5)
        en2 = 1'b0;
        @(negedge clk);
        chk(r2 && !r1, "R3 middle enable low", {r1, r2}, 1);
        @(negedge clk);
        chk(r3, "R4 downstream start low", r3, 1);
        en2 = 1'b1;
        measure(f1, f2, f3);
        chk(f2 == DLY, "R5 middle restart delay", f2, DLY);
        chk(f3 == 2 * DLY, "R7 downstream after restart", f3, 2 * DLY);

        // R1 asynchronous assertion, R8 long run-time reset
        @(negedge clk);
        rst_i = 1'b1;
        #1;
        chk(r1 && r2 && r3, "R1 asynchronous assertion", {r1, r2, r3}, 7);
        repeat (40) @(negedge clk);
        chk(r1 && r2 && r3 && !rn1 && !rn2 && !rn3, "R1 held through long reset", {r1, r2, r3}, 7);
        rst_i = 1'b0;
        measure(f1, f2, f3);
        chk(f1 == SYN + DLY, "R8 first stage after long reset", f1, SYN + DLY);
        chk(f2 == SYN + 2 * DLY, "R8 second stage after long reset", f2, SYN + 2 * DLY);
        chk(f3 == SYN + 3 * DLY, "R8 third stage after long reset", f3, SYN + 3 * DLY);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule